// File: doc/BRIEF.md
# Dual 8-bit Cascadable Timer

The block holds two 8-bit up-counters, a high half and a low half. When the mode input is low they run independently. When it is high they form one 16-bit counter whose high half takes the low half's wrap as a carry. Each half has its own compare register, compare flag and overflow flag. Each half also has an enable for its overflow interrupt request and an enable that clears the counter on a compare match. A single 8-bit control/status byte holds all four flags and all four enables.

Software reaches the counters, the compare registers and the control/status byte over a small register bus. The bus has an address, separate write and read strobes, and 8-bit data in each direction. A flag can only be cleared by a write of 0 that follows a read in which that flag was seen as 1. The block raises one interrupt request line per half. Clock prescaling, output pins and interrupt routing are outside the block.

Top module: `dual8_timer`

## Requirements
- R1: The control/status byte (address 0) holds, from bit 7 to bit 0: high overflow flag, high compare flag, high overflow interrupt enable, high clear-on-match enable, low overflow flag, low compare flag, low overflow interrupt enable, low clear-on-match enable. Bits 5, 4, 1 and 0 are plain read/write. The other addresses are 1 low counter, 2 high counter, 3 low compare and 4 high compare.
- R2: After reset the control/status byte and both counters read 0x00, both compare registers read 0xFF, and both interrupt lines are low.
- R3: Writing 1 to a flag bit leaves the flag unchanged. Writing 0 to a flag bit that has not been read as 1 since it was last cleared also leaves it unchanged.
- R4: A write of 0 to a flag bit clears the flag when that flag was read as 1 by an earlier read of the control/status byte.
- R5: In 8-bit mode, a half's overflow flag sets on the enabled count that takes that counter from 0xFF to 0x00.
- R6: In 8-bit mode, a half's compare flag sets on an enabled count at which the counter equals its compare register. In that case, if the half's clear-on-match enable is 1, the counter goes to 0x00 instead of incrementing.
- R7: In 8-bit mode the high clear-on-match enable clears only the high counter. The low counter keeps counting.
- R8: In 16-bit mode a low-half wrap increments the high half and sets the low overflow flag. A wrap of the full value from 0xFFFF to 0x0000 also sets the high overflow flag.
- R9: In 16-bit mode the high compare flag sets when {high, low} equals {high compare, low compare}. With the high clear-on-match enable set, this match clears the whole 16-bit counter. The low clear-on-match enable has no effect in this mode, although the low compare flag still follows the low byte.
- R10: Each interrupt request line is high exactly while its half's overflow flag and overflow interrupt enable are both 1.
- R11: If a flag's set condition and a valid clearing write fall in the same cycle, the flag stays set.
- R12: Each clock with the count enable high advances the counters by one. A counter write loads its byte and suppresses counting in that cycle. Read data appears on the clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode16_i | input | 1 | 1 joins the halves into one 16-bit counter |
| cnt_en_i | input | 1 | Count enable, one increment per enabled clock |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, registered |
| irq_hi_o | output | 1 | High half overflow interrupt request |
| irq_lo_o | output | 1 | Low half overflow interrupt request |

## Verification
Counter values and flags change on the clock edge of the enabled count, so they are visible on the following read. Read data is registered and due one clock after the read strobe. The interrupt lines follow the flag and enable registers in the same cycle that either of them changes. The bench drives all inputs at the falling edge and holds each strobe for exactly one rising edge. It samples read data and interrupt lines at the next falling edge, so every result is taken exactly one register stage after its stimulus.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam int ADR_W = 3;
  localparam logic [ADR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADR_W-1:0] A_CNT_HI = 3'd2;
  localparam logic [ADR_W-1:0] A_CMP_LO = 3'd3;
  localparam logic [ADR_W-1:0] A_CMP_HI = 3'd4;

  // flag / event index order
  localparam int NFLAG   = 4;
  localparam int F_OVF_H = 0;
  localparam int F_CMP_H = 1;
  localparam int F_OVF_L = 2;
  localparam int F_CMP_L = 3;

  // enable bit positions in the control byte
  localparam int B_OVIE_H = 5;
  localparam int B_CLR_H  = 4;
  localparam int B_OVIE_L = 1;
  localparam int B_CLR_L  = 0;

  // control-byte position of flag i: 7,6,3,2
  function automatic int flag_pos(int i);
    return (i < 2) ? (7 - i) : (5 - i);
  endfunction
endpackage

// File: rtl/dt_counter.sv
module dt_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode16,
  input  logic          cnt_en,
  input  logic          clr_hi_en,
  input  logic          clr_lo_en,
  input  logic [DW-1:0] cmp_hi,
  input  logic [DW-1:0] cmp_lo,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cnt_hi,
  output logic [DW-1:0] cnt_lo,
  output logic [3:0]    evt
);
  import dt_pkg::*;
  localparam logic [DW-1:0] TOP = '1;

  logic [DW-1:0] lo_d, hi_d;
  logic adv, m_lo, m_hi, m_full;

  always_comb begin
    adv    = cnt_en & ~wr_lo & ~wr_hi;
    m_lo   = (cnt_lo == cmp_lo);
    m_hi   = (cnt_hi == cmp_hi);
    m_full = m_lo & m_hi;
    lo_d   = cnt_lo;
    hi_d   = cnt_hi;
    evt    = '0;
    if (wr_lo) lo_d = wdata;
    if (wr_hi) hi_d = wdata;
    if (adv) begin
      if (mode16) begin
        evt[F_CMP_L] = m_lo;
        evt[F_CMP_H] = m_full;
        if (clr_hi_en && m_full) begin
          lo_d = '0;
          hi_d = '0;
        end else begin
          lo_d = cnt_lo + 1'b1;
          if (cnt_lo == TOP) begin
            evt[F_OVF_L] = 1'b1;
            hi_d         = cnt_hi + 1'b1;
            evt[F_OVF_H] = (cnt_hi == TOP);
          end
        end
      end else begin
        evt[F_CMP_L] = m_lo;
        evt[F_CMP_H] = m_hi;
        if (clr_lo_en && m_lo) lo_d = '0;
        else begin
          lo_d         = cnt_lo + 1'b1;
          evt[F_OVF_L] = (cnt_lo == TOP);
        end
        if (clr_hi_en && m_hi) hi_d = '0;
        else begin
          hi_d         = cnt_hi + 1'b1;
          evt[F_OVF_H] = (cnt_hi == TOP);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else begin
      cnt_lo <= lo_d;
      cnt_hi <= hi_d;
    end
  end
endmodule

// File: rtl/dt_flag.sv
module dt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic clr_wr_i,
  output logic flag_o
);
  logic arm_q, arm_d, flag_d, consume;

  always_comb begin
    consume = clr_wr_i & arm_q;
    flag_d  = set_i | (flag_o & ~consume);
    arm_d   = consume ? 1'b0 : (arm_q | (rd_i & flag_o));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_o <= flag_d;
      arm_q  <= arm_d;
    end
  end
endmodule

// File: rtl/dt_regs.sv
module dt_regs #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  input  logic [3:0]    flags,
  input  logic [DW-1:0] cnt_hi,
  input  logic [DW-1:0] cnt_lo,
  output logic [DW-1:0] cmp_hi,
  output logic [DW-1:0] cmp_lo,
  output logic [3:0]    en_q,
  output logic          wr_ctrl,
  output logic          rd_ctrl,
  output logic          wr_lo,
  output logic          wr_hi,
  output logic [DW-1:0] rdata
);
  import dt_pkg::*;

  logic [7:0]    ctrl;
  logic [DW-1:0] rd_mux, cmp_hi_d, cmp_lo_d;
  logic [3:0]    en_d;

  always_comb begin
    wr_ctrl = wr_en && (addr == A_CTRL);
    rd_ctrl = rd_en && (addr == A_CTRL);
    wr_lo   = wr_en && (addr == A_CNT_LO);
    wr_hi   = wr_en && (addr == A_CNT_HI);
    ctrl    = {flags[F_OVF_H], flags[F_CMP_H], en_q[3], en_q[2],
               flags[F_OVF_L], flags[F_CMP_L], en_q[1], en_q[0]};
    cmp_hi_d = (wr_en && addr == A_CMP_HI) ? wdata : cmp_hi;
    cmp_lo_d = (wr_en && addr == A_CMP_LO) ? wdata : cmp_lo;
    en_d     = wr_ctrl ? {wdata[B_OVIE_H], wdata[B_CLR_H],
                          wdata[B_OVIE_L], wdata[B_CLR_L]} : en_q;
    case (addr)
      A_CTRL:   rd_mux = DW'(ctrl);
      A_CNT_LO: rd_mux = cnt_lo;
      A_CNT_HI: rd_mux = cnt_hi;
      A_CMP_LO: rd_mux = cmp_lo;
      A_CMP_HI: rd_mux = cmp_hi;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_hi <= '1;
      cmp_lo <= '1;
      en_q   <= '0;
      rdata  <= '0;
    end else begin
      cmp_hi <= cmp_hi_d;
      cmp_lo <= cmp_lo_d;
      en_q   <= en_d;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dual8_timer.sv
module dual8_timer #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode16_i,
  input  logic          cnt_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_hi_o,
  output logic          irq_lo_o
);
  import dt_pkg::*;

  logic          rst_meta, rst_sync_n;
  logic [DW-1:0] cnt_hi, cnt_lo, cmp_hi, cmp_lo;
  logic [3:0]    evt, flag_q, en_q;
  logic          wr_ctrl, rd_ctrl, wr_lo, wr_hi;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  dt_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .addr(addr_i), .wr_en(wr_en_i),
    .rd_en(rd_en_i), .wdata(wdata_i), .flags(flag_q), .cnt_hi(cnt_hi),
    .cnt_lo(cnt_lo), .cmp_hi(cmp_hi), .cmp_lo(cmp_lo), .en_q(en_q),
    .wr_ctrl(wr_ctrl), .rd_ctrl(rd_ctrl), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .rdata(rdata_o)
  );

  dt_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .mode16(mode16_i), .cnt_en(cnt_en_i),
    .clr_hi_en(en_q[2]), .clr_lo_en(en_q[0]), .cmp_hi(cmp_hi),
    .cmp_lo(cmp_lo), .wr_lo(wr_lo), .wr_hi(wr_hi), .wdata(wdata_i),
    .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .evt(evt)
  );

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    localparam int POS = flag_pos(i);
    dt_flag u_flag (
      .clk(clk), .rst_n(rst_sync_n), .set_i(evt[i]), .rd_i(rd_ctrl),
      .clr_wr_i(wr_ctrl & ~wdata_i[POS]), .flag_o(flag_q[i])
    );
  end

  assign irq_hi_o = flag_q[F_OVF_H] & en_q[3];
  assign irq_lo_o = flag_q[F_OVF_L] & en_q[1];
endmodule

module dt_checker #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cnt_en,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] cnt_lo,
  input logic [DW-1:0] cnt_hi,
  input logic [DW-1:0] cmp_hi,
  input logic [3:0]    flags
);
  // R3
  lo_ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flags[2]) |-> $past(wr_en && addr == 3'd0 && !wdata[3]));
  // R5
  lo_ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> ($past(cnt_lo) == '1));
  // R8
  hi_ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> ($past(cnt_hi) == '1));
  // R9
  hi_cmp_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[1]) |-> $past(cnt_hi == cmp_hi));
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_en) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
endmodule

bind dual8_timer dt_checker #(.DW(DW), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .cnt_en(cnt_en_i), .wr_en(wr_en_i),
  .addr(addr_i), .wdata(wdata_i), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
  .cmp_hi(cmp_hi), .flags(flag_q)
);

// File: tb/test_dual8_timer.sv
module test_dual8_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode16 = 1'b0, cnt_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_hi, irq_lo;
  int checks = 0, fails = 0;
  logic [7:0] v, h0;

  always #10 clk = ~clk;

  dual8_timer i_dual8_timer (
    .clk(clk), .rst_n(rst_n), .mode16_i(mode16), .cnt_en_i(cnt_en),
    .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en), .wdata_i(wdata),
    .rdata_o(rdata), .irq_hi_o(irq_hi), .irq_lo_o(irq_lo)
  );

  task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic step(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic clean();
    logic [7:0] t;
    rd(3'd0, t);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_reset();
    rd(3'd0, v); chk(v, 8'h00, "R2 ctrl");
    rd(3'd1, v); chk(v, 8'h00, "R2 cnt_lo");
    rd(3'd2, v); chk(v, 8'h00, "R2 cnt_hi");
    rd(3'd3, v); chk(v, 8'hFF, "R2 cmp_lo");
    rd(3'd4, v); chk(v, 8'hFF, "R2 cmp_hi");
    chk({6'd0, irq_hi, irq_lo}, 8'h00, "R2 irq");
  endtask

  task automatic t_ovf8();
    wr(3'd3, 8'h80);
    wr(3'd1, 8'hFE);
    step(2);
    rd(3'd1, v); chk(v, 8'h00, "R5 lo wrap");
    rd(3'd2, v); chk(v, 8'h02, "R12 hi counts");
    rd(3'd0, v); chk(v, 8'h08, "R5 R1 ovf lo bit3");
  endtask

  task automatic t_flag_clear();
    wr(3'd1, 8'hFF);
    step(1);                       // ovf lo set, not yet read
    wr(3'd0, 8'h00);
    rd(3'd0, v); chk(v, 8'h08, "R3 zero write without read");
    wr(3'd0, 8'h08);
    rd(3'd0, v); chk(v, 8'h08, "R3 write of one");
    wr(3'd0, 8'h00);
    rd(3'd0, v); chk(v, 8'h00, "R4 read then clear");
  endtask

  task automatic t_irq();
    wr(3'd1, 8'hFF);
    step(1);
    wr(3'd0, 8'h0A);
    chk({6'd0, irq_hi, irq_lo}, 8'h01, "R10 irq lo on");
    wr(3'd0, 8'h08);
    chk({6'd0, irq_hi, irq_lo}, 8'h00, "R10 irq lo off");
    clean();
  endtask

  task automatic t_cmp8();
    wr(3'd3, 8'h05);
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h03);
    step(3);
    rd(3'd1, v); chk(v, 8'h00, "R6 lo clear on match");
    rd(3'd0, v); chk(v, 8'h05, "R6 cmp lo flag");
    clean();
    wr(3'd1, 8'h04);
    step(2);
    rd(3'd1, v); chk(v, 8'h06, "R6 no clear when disabled");
    rd(3'd0, v); chk(v, 8'h04, "R6 flag without clear");
    clean();
    wr(3'd3, 8'h80);
  endtask

  task automatic t_casc();
    mode16 = 1'b1;
    wr(3'd2, 8'h12); wr(3'd1, 8'hFF);
    step(1);
    rd(3'd2, v); chk(v, 8'h13, "R8 carry into hi");
    rd(3'd1, v); chk(v, 8'h00, "R8 lo wrapped");
    rd(3'd0, v); chk(v, 8'h08, "R8 only lo ovf");
    clean();
    wr(3'd2, 8'hFF); wr(3'd1, 8'hFF);
    step(1);
    rd(3'd2, v); chk(v, 8'h00, "R8 full wrap hi");
    rd(3'd0, v); chk(v, 8'h88, "R8 both ovf");
    wr(3'd0, 8'hA8);
    chk({6'd0, irq_hi, irq_lo}, 8'h02, "R10 irq hi on");
    clean();
    chk({6'd0, irq_hi, irq_lo}, 8'h00, "R10 irq hi off");
  endtask

  task automatic t_cmp16();
    wr(3'd4, 8'h12); wr(3'd3, 8'h34);
    wr(3'd0, 8'h10);
    wr(3'd2, 8'h12); wr(3'd1, 8'h33);
    step(2);
    rd(3'd2, v); chk(v, 8'h00, "R9 full clear hi");
    rd(3'd1, v); chk(v, 8'h00, "R9 full clear lo");
    rd(3'd0, v); chk(v, 8'h54, "R9 cmp flags");
    clean();
    wr(3'd0, 8'h01);
    wr(3'd1, 8'h33);
    step(2);
    rd(3'd1, v); chk(v, 8'h35, "R9 lo clear ignored");
    rd(3'd0, v); chk(v, 8'h05, "R9 lo cmp flag");
    clean();
    mode16 = 1'b0;
  endtask

  task automatic t_hiclr8();
    wr(3'd4, 8'h07);
    wr(3'd0, 8'h10);
    wr(3'd2, 8'h07); wr(3'd1, 8'h20);
    step(1);
    rd(3'd2, v); chk(v, 8'h00, "R7 hi cleared");
    rd(3'd1, v); chk(v, 8'h21, "R7 lo keeps counting");
    rd(3'd0, v); chk(v, 8'h50, "R7 cmp hi flag");
    clean();
  endtask

  task automatic t_same_cycle();
    wr(3'd3, 8'h80);
    wr(3'd1, 8'hFF);
    step(1);
    rd(3'd0, v);                   // arms ovf lo
    wr(3'd1, 8'hFF);
    addr = 3'd0; wdata = 8'h00; wr_en = 1'b1; cnt_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cnt_en = 1'b0;
    rd(3'd0, v); chk(v, 8'h08, "R11 set wins");
    clean();
  endtask

  task automatic t_wr_suppress();
    rd(3'd2, h0);
    addr = 3'd1; wdata = 8'h10; wr_en = 1'b1; cnt_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
    cnt_en = 1'b0;
    rd(3'd1, v); chk(v, 8'h11, "R12 write beats count");
    rd(3'd2, v); chk(v, h0 + 8'd1, "R12 hi held during write");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ovf8();
    clean();
    t_flag_clear();
    t_irq();
    t_cmp8();
    t_casc();
    t_cmp16();
    t_hiclr8();
    t_same_cycle();
    t_wr_suppress();
    finish_run();
  end
endmodule